// File: doc/BRIEF.md
# Two-Tier Line Location Controller

In a tiled multicore where lines may be migrated or placed away from the tile their address names, a requester needs to find the tile that currently holds a line. This controller sits in each tile and steers one request at a time through a two-tier search. It first asks the tile's own pointer cache, a near table of copied host pointers. If that misses, it asks the line's home tile, where the authoritative pointer table and the L2 bank are probed together. If both miss there, it asks the placement policy where the line fetched from memory should go.

The controller issues one probe at a time and waits for the matching response. It then produces a single routing decision: near-pointer hit, home-pointer hit, home L2 hit, or memory fetch. In the same cycle it issues the pointer-table writes that keep the two tiers in step. A pointer is only ever recorded for a line whose host is not its home. The tables, the network and the placement policy are outside the block and are reached only through request and response ports.

The home tile is taken from the line-address bits just above the line offset. A parameter can select an XOR fold of two such fields instead.

Top module: `line_locator`

## Requirements
- R1: Every accepted request first raises `near_look_valid` for one cycle. If the near response reports a hit, the decision is kind 2'b00 with `route_tile` equal to the reported host. No home probe, placement request or pointer write follows.
- R2: On a near miss, `home_look_valid` pulses once, one cycle after the response. `home_look_addr` is the request address and `home_look_tile` is address bits [9:6] (the 4 line-address bits above the 64-byte offset, with 16 tiles).
- R3: A principal hit is decision kind 2'b01 to the recorded host, and it takes priority over an L2 hit reported in the same response. It also writes a near pointer (request address, that host) and sends a sharer-only update (`auth_upd_new` = 0) to the home tile.
- R4: A principal miss with an L2 hit is decision kind 2'b10, with `route_tile` equal to the home tile. It writes no pointers and raises no placement request.
- R5: When the principal table and the L2 bank both miss, `place_req_valid` pulses once and the decision is kind 2'b11 to the placement tile. If that tile differs from the home tile, a near pointer and a new principal entry (`auth_upd_new` = 1) with that host are written. If it equals the home tile, nothing is written.
- R6: Every home-side update carries a sharer mask in which only bit number `req_src` is set.
- R7: `busy` rises in the cycle after a request is accepted and falls in the cycle its decision appears. A `req_valid` seen while busy is dropped and never probed.
- R8: A response that arrives while the controller is not waiting for that response changes neither the decision nor the probes.
- R9: The decision and any pointer writes appear together as one-cycle pulses, exactly one cycle after the response that settles the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New location request |
| req_addr | input | ADDR_W | Physical address of the line |
| req_src | input | TILE_W | Requesting tile number |
| busy | output | 1 | A request is being resolved |
| near_look_valid | output | 1 | Probe of the near pointer table |
| near_look_addr | output | ADDR_W | Address probed in the near table |
| near_rsp_valid | input | 1 | Near table response |
| near_rsp_hit | input | 1 | Near table holds a pointer |
| near_rsp_host | input | TILE_W | Host recorded in the near table |
| home_look_valid | output | 1 | Probe of the home tile (pointer table and L2) |
| home_look_tile | output | TILE_W | Home tile of the line |
| home_look_addr | output | ADDR_W | Address probed at home |
| home_rsp_valid | input | 1 | Home response |
| home_rsp_ptr_hit | input | 1 | Principal pointer present |
| home_rsp_ptr_host | input | TILE_W | Host recorded by the principal pointer |
| home_rsp_l2_hit | input | 1 | Line present in the home L2 bank |
| place_req_valid | output | 1 | Ask the placement policy for a tile |
| place_rsp_valid | input | 1 | Placement answer |
| place_rsp_tile | input | TILE_W | Tile chosen for the fetched line |
| route_valid | output | 1 | Routing decision pulse |
| route_kind | output | 2 | 00 near hit, 01 home pointer, 10 home L2, 11 memory |
| route_tile | output | TILE_W | Tile the request is sent to |
| near_put_valid | output | 1 | Write a pointer into the near table |
| near_put_addr | output | ADDR_W | Address of that pointer |
| near_put_host | output | TILE_W | Host written into the near table |
| auth_upd_valid | output | 1 | Update the principal table at home |
| auth_upd_new | output | 1 | 1 writes a new entry, 0 only adds a sharer |
| auth_upd_tile | output | TILE_W | Home tile holding the entry |
| auth_upd_host | output | TILE_W | Host written with a new entry |
| auth_upd_mask | output | TILES | Sharer bits to set |

## Verification
The bench drives requests along each of the four resolution paths, so the kind of each decision shows which tier actually settled the request. It also drives a principal hit and an L2 hit in the same response, which shows whether the priority is right. Memory fetches are placed once away from home and once at home, to show that pointers are written only for displaced lines. Response latencies vary, and the bench adds stray responses, a second request while busy, and extreme addresses and requester numbers. These show that waiting is tied to the probe the controller issued, that extra traffic is dropped, and that the home field and sharer bit are taken from the right bits.

// File: rtl/line_loc_pkg.sv
package line_loc_pkg;
   typedef enum logic [1:0] {
      RT_NEAR    = 2'b00,
      RT_HOMEPTR = 2'b01,
      RT_HOMEL2  = 2'b10,
      RT_MEMORY  = 2'b11
   } route_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_NEAR_WAIT,
      ST_HOME_WAIT,
      ST_PLACE_WAIT
   } seq_state_t;
endpackage

// File: rtl/loc_home_sel.sv
module loc_home_sel #(
   parameter int TILE_W = 4,
   parameter int FOLD   = 0,
   localparam int SEL_W = (FOLD != 0) ? 2 * TILE_W : TILE_W
) (
   input  logic [SEL_W-1:0]  field,
   output logic [TILE_W-1:0] home
);
   generate
      if (FOLD == 0) begin : g_direct
         assign home = field;
      end else begin : g_fold
         assign home = field[TILE_W-1:0] ^ field[SEL_W-1:TILE_W];
      end
   endgenerate
endmodule

// File: rtl/loc_seq.sv
module loc_seq
   import line_loc_pkg::*;
#(
   parameter int TILE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TILE_W-1:0] home_tile,
   input  logic              near_rsp_valid,
   input  logic              near_rsp_hit,
   input  logic [TILE_W-1:0] near_rsp_host,
   input  logic              home_rsp_valid,
   input  logic              home_rsp_ptr_hit,
   input  logic [TILE_W-1:0] home_rsp_ptr_host,
   input  logic              home_rsp_l2_hit,
   input  logic              place_rsp_valid,
   input  logic [TILE_W-1:0] place_rsp_tile,
   output logic              accept,
   output logic              busy,
   output logic              probe_near,
   output logic              probe_home,
   output logic              probe_place,
   output logic              dec_valid,
   output route_kind_t       dec_kind,
   output logic [TILE_W-1:0] dec_tile,
   output logic              dec_put,
   output logic              dec_new
);
   seq_state_t state, nxt;
   logic       go_home, go_place;

   assign accept = (state == ST_IDLE) && req_valid;
   assign busy   = (state != ST_IDLE);

   always_comb begin
      nxt       = state;
      dec_valid = 1'b0;
      dec_kind  = RT_NEAR;
      dec_tile  = '0;
      dec_put   = 1'b0;
      dec_new   = 1'b0;
      go_home   = 1'b0;
      go_place  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) nxt = ST_NEAR_WAIT;
         end
         ST_NEAR_WAIT: begin
            if (near_rsp_valid) begin
               if (near_rsp_hit) begin
                  dec_valid = 1'b1;
                  dec_kind  = RT_NEAR;
                  dec_tile  = near_rsp_host;
                  nxt       = ST_IDLE;
               end else begin
                  go_home = 1'b1;
                  nxt     = ST_HOME_WAIT;
               end
            end
         end
         ST_HOME_WAIT: begin
            if (home_rsp_valid) begin
               if (home_rsp_ptr_hit) begin
                  dec_valid = 1'b1;
                  dec_kind  = RT_HOMEPTR;
                  dec_tile  = home_rsp_ptr_host;
                  dec_put   = 1'b1;
                  nxt       = ST_IDLE;
               end else if (home_rsp_l2_hit) begin
                  dec_valid = 1'b1;
                  dec_kind  = RT_HOMEL2;
                  dec_tile  = home_tile;
                  nxt       = ST_IDLE;
               end else begin
                  go_place = 1'b1;
                  nxt      = ST_PLACE_WAIT;
               end
            end
         end
         ST_PLACE_WAIT: begin
            if (place_rsp_valid) begin
               dec_valid = 1'b1;
               dec_kind  = RT_MEMORY;
               dec_tile  = place_rsp_tile;
               dec_put   = (place_rsp_tile != home_tile);
               dec_new   = (place_rsp_tile != home_tile);
               nxt       = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         probe_near  <= 1'b0;
         probe_home  <= 1'b0;
         probe_place <= 1'b0;
      end else begin
         state       <= nxt;
         probe_near  <= accept;
         probe_home  <= go_home;
         probe_place <= go_place;
      end
   end

   AST_ONE_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({probe_near, probe_home, probe_place})); // R7
   AST_NEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> probe_near); // R1
   AST_PROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_near || probe_home || probe_place) |-> busy); // R7
   AST_NO_HOME_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !probe_home && !probe_place); // R8
endmodule

// File: rtl/loc_cmd.sv
module loc_cmd
   import line_loc_pkg::*;
#(
   parameter int TILES  = 16,
   parameter int ADDR_W = 32,
   localparam int TILE_W = $clog2(TILES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TILE_W-1:0] req_src,
   input  logic [TILE_W-1:0] home_tile,
   input  logic              dec_valid,
   input  route_kind_t       dec_kind,
   input  logic [TILE_W-1:0] dec_tile,
   input  logic              dec_put,
   input  logic              dec_new,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              route_valid,
   output logic [1:0]        route_kind,
   output logic [TILE_W-1:0] route_tile,
   output logic              near_put_valid,
   output logic [TILE_W-1:0] near_put_host,
   output logic              auth_upd_valid,
   output logic              auth_upd_new,
   output logic [TILE_W-1:0] auth_upd_host,
   output logic [TILES-1:0]  auth_upd_mask
);
   logic [TILE_W-1:0] cur_src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr       <= '0;
         cur_src        <= '0;
         route_valid    <= 1'b0;
         route_kind     <= 2'b00;
         route_tile     <= '0;
         near_put_valid <= 1'b0;
         near_put_host  <= '0;
         auth_upd_valid <= 1'b0;
         auth_upd_new   <= 1'b0;
         auth_upd_host  <= '0;
      end else begin
         if (accept) begin
            cur_addr <= req_addr;
            cur_src  <= req_src;
         end
         route_valid    <= dec_valid;
         route_kind     <= dec_kind;
         route_tile     <= dec_tile;
         near_put_valid <= dec_valid && dec_put;
         near_put_host  <= dec_tile;
         auth_upd_valid <= dec_valid && dec_put;
         auth_upd_new   <= dec_new;
         auth_upd_host  <= dec_tile;
      end
   end

   generate
      for (genvar i = 0; i < TILES; i++) begin : g_mask
         assign auth_upd_mask[i] = (cur_src == TILE_W'(i));
      end
   endgenerate

   AST_PUT_WITH_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (near_put_valid || auth_upd_valid) |-> route_valid); // R9
   AST_ROUTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |=> !route_valid); // R9
   AST_NEAR_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_kind == 2'b00) |-> !near_put_valid && !auth_upd_valid); // R1
   AST_L2_AT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_kind == 2'b10) |-> (route_tile == home_tile) && !near_put_valid); // R4
   AST_NEW_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (auth_upd_valid && auth_upd_new) |-> (auth_upd_host != home_tile)); // R5
endmodule

// File: rtl/line_locator.sv
module line_locator
   import line_loc_pkg::*;
#(
   parameter int TILES     = 16,
   parameter int ADDR_W    = 32,
   parameter int OFFSET_W  = 6,
   parameter int HOME_FOLD = 0,
   localparam int TILE_W   = $clog2(TILES),
   localparam int SEL_W    = (HOME_FOLD != 0) ? 2 * TILE_W : TILE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TILE_W-1:0] req_src,
   output logic              busy,
   output logic              near_look_valid,
   output logic [ADDR_W-1:0] near_look_addr,
   input  logic              near_rsp_valid,
   input  logic              near_rsp_hit,
   input  logic [TILE_W-1:0] near_rsp_host,
   output logic              home_look_valid,
   output logic [TILE_W-1:0] home_look_tile,
   output logic [ADDR_W-1:0] home_look_addr,
   input  logic              home_rsp_valid,
   input  logic              home_rsp_ptr_hit,
   input  logic [TILE_W-1:0] home_rsp_ptr_host,
   input  logic              home_rsp_l2_hit,
   output logic              place_req_valid,
   input  logic              place_rsp_valid,
   input  logic [TILE_W-1:0] place_rsp_tile,
   output logic              route_valid,
   output logic [1:0]        route_kind,
   output logic [TILE_W-1:0] route_tile,
   output logic              near_put_valid,
   output logic [ADDR_W-1:0] near_put_addr,
   output logic [TILE_W-1:0] near_put_host,
   output logic              auth_upd_valid,
   output logic              auth_upd_new,
   output logic [TILE_W-1:0] auth_upd_tile,
   output logic [TILE_W-1:0] auth_upd_host,
   output logic [TILES-1:0]  auth_upd_mask
);
   if (TILES < 2 || (TILES & (TILES - 1)) != 0) begin : g_bad_tiles
      $error("line_locator: TILES must be a power of two of at least 2");
   end
   if (OFFSET_W + SEL_W > ADDR_W) begin : g_bad_addr
      $error("line_locator: address too narrow for the home field");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic [TILE_W-1:0] home_tile;
   logic              accept, dec_valid, dec_put, dec_new;
   route_kind_t       dec_kind;
   logic [TILE_W-1:0] dec_tile;

   loc_home_sel #(.TILE_W(TILE_W), .FOLD(HOME_FOLD)) u_home (
      .field (cur_addr[OFFSET_W +: SEL_W]),
      .home  (home_tile)
   );

   loc_seq #(.TILE_W(TILE_W)) u_seq (
      .clk               (clk),
      .rst_n             (rst_n),
      .req_valid         (req_valid),
      .home_tile         (home_tile),
      .near_rsp_valid    (near_rsp_valid),
      .near_rsp_hit      (near_rsp_hit),
      .near_rsp_host     (near_rsp_host),
      .home_rsp_valid    (home_rsp_valid),
      .home_rsp_ptr_hit  (home_rsp_ptr_hit),
      .home_rsp_ptr_host (home_rsp_ptr_host),
      .home_rsp_l2_hit   (home_rsp_l2_hit),
      .place_rsp_valid   (place_rsp_valid),
      .place_rsp_tile    (place_rsp_tile),
      .accept            (accept),
      .busy              (busy),
      .probe_near        (near_look_valid),
      .probe_home        (home_look_valid),
      .probe_place       (place_req_valid),
      .dec_valid         (dec_valid),
      .dec_kind          (dec_kind),
      .dec_tile          (dec_tile),
      .dec_put           (dec_put),
      .dec_new           (dec_new)
   );

   loc_cmd #(.TILES(TILES), .ADDR_W(ADDR_W)) u_cmd (
      .clk            (clk),
      .rst_n          (rst_n),
      .accept         (accept),
      .req_addr       (req_addr),
      .req_src        (req_src),
      .home_tile      (home_tile),
      .dec_valid      (dec_valid),
      .dec_kind       (dec_kind),
      .dec_tile       (dec_tile),
      .dec_put        (dec_put),
      .dec_new        (dec_new),
      .cur_addr       (cur_addr),
      .route_valid    (route_valid),
      .route_kind     (route_kind),
      .route_tile     (route_tile),
      .near_put_valid (near_put_valid),
      .near_put_host  (near_put_host),
      .auth_upd_valid (auth_upd_valid),
      .auth_upd_new   (auth_upd_new),
      .auth_upd_host  (auth_upd_host),
      .auth_upd_mask  (auth_upd_mask)
   );

   assign near_look_addr = cur_addr;
   assign home_look_addr = cur_addr;
   assign home_look_tile = home_tile;
   assign near_put_addr  = cur_addr;
   assign auth_upd_tile  = home_tile;

   AST_DECIDE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> !busy); // R7
   AST_PLACE_ONLY_AFTER_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      place_req_valid |-> $past(home_rsp_valid) && !$past(home_rsp_ptr_hit)); // R5
endmodule

// File: tb/line_locator_test.sv
`timescale 1ns/1ps
module line_locator_test;
   localparam int TILES = 16, ADDR_W = 32, TILE_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [TILE_W-1:0] req_src = '0;
   logic busy, near_look_valid, home_look_valid, place_req_valid;
   logic [ADDR_W-1:0] near_look_addr, home_look_addr, near_put_addr;
   logic near_rsp_valid = 1'b0, near_rsp_hit = 1'b0;
   logic [TILE_W-1:0] near_rsp_host = '0;
   logic home_rsp_valid = 1'b0, home_rsp_ptr_hit = 1'b0, home_rsp_l2_hit = 1'b0;
   logic [TILE_W-1:0] home_rsp_ptr_host = '0;
   logic place_rsp_valid = 1'b0;
   logic [TILE_W-1:0] place_rsp_tile = '0;
   logic [TILE_W-1:0] home_look_tile, route_tile, near_put_host, auth_upd_tile, auth_upd_host;
   logic route_valid, near_put_valid, auth_upd_valid, auth_upd_new;
   logic [1:0] route_kind;
   logic [TILES-1:0] auth_upd_mask;

   always #4 clk = ~clk;

   line_locator #(.TILES(TILES), .ADDR_W(ADDR_W)) uut (.*);

   typedef struct {
      string             tag;
      logic [1:0]        kind;
      logic [TILE_W-1:0] tile;
      bit                put;
      bit                isnew;
      logic [ADDR_W-1:0] addr;
      logic [TILE_W-1:0] src;
      logic [TILE_W-1:0] home;
   } exp_t;

   exp_t expq[$];
   int checks = 0, fails = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference comparison on every clock: decisions against the queue of expected outcomes
   exp_t e;
   always @(negedge clk) begin
      if (rst_n) begin
         if (route_valid) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R8", "route with no request", route_kind, 0);
            end else begin
               e = expq.pop_front();
               chk(route_kind == e.kind, e.tag, "route kind", route_kind, e.kind);
               chk(route_tile == e.tile, e.tag, "route tile", route_tile, e.tile);
               chk(near_put_valid == e.put, e.tag, "near pointer write", near_put_valid, e.put);
               chk(auth_upd_valid == (e.put || e.kind == 2'b01), e.tag, "home update",
                   auth_upd_valid, (e.put || e.kind == 2'b01));
               if (e.put) begin
                  chk(near_put_addr == e.addr && near_put_host == e.tile, e.tag,
                      "near pointer content", near_put_host, e.tile);
               end
               if (auth_upd_valid) begin
                  chk(auth_upd_new == e.isnew, e.tag, "update is new entry", auth_upd_new, e.isnew);
                  chk(auth_upd_tile == e.home, e.tag, "update home tile", auth_upd_tile, e.home);
                  chk(auth_upd_mask == (16'h1 << e.src), "R6", "sharer mask",
                      auth_upd_mask, (16'h1 << e.src));
                  if (e.isnew)
                     chk(auth_upd_host == e.tile, e.tag, "new entry host", auth_upd_host, e.tile);
               end
            end
         end else if (near_put_valid || auth_upd_valid) begin
            chk(1'b0, "R9", "pointer write without decision", near_put_valid, 0);
         end
      end
   end

   task automatic run(string tag, logic [ADDR_W-1:0] addr, logic [TILE_W-1:0] src,
                      bit nhit, logic [TILE_W-1:0] nhost, bit phit, logic [TILE_W-1:0] phost,
                      bit l2, logic [TILE_W-1:0] ptile, int dly, bit stray, bit extra);
      exp_t x;
      logic [TILE_W-1:0] home;
      int nn = 0, nh = 0, np = 0, en = 1, eh = 0, ep = 0;
      int cn = -1, ch = -1, cp = -1, dec_at = -1;
      bit seen = 0, busy_ok = 1;
      home = addr[9:6];
      x.tag = tag; x.addr = addr; x.src = src; x.home = home; x.put = 0; x.isnew = 0;
      if (nhit) begin
         x.kind = 2'b00; x.tile = nhost;
      end else if (phit) begin
         x.kind = 2'b01; x.tile = phost; x.put = 1; eh = 1;
      end else if (l2) begin
         x.kind = 2'b10; x.tile = home; eh = 1;
      end else begin
         x.kind = 2'b11; x.tile = ptile; eh = 1; ep = 1;
         x.put = (ptile != home); x.isnew = (ptile != home);
      end
      expq.push_back(x);
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_src = src;
      for (int cyc = 0; cyc < 60 && !seen; cyc++) begin
         @(negedge clk);
         req_valid = 1'b0; near_rsp_valid = 1'b0; home_rsp_valid = 1'b0; place_rsp_valid = 1'b0;
         if (route_valid) begin
            seen = 1;
            chk(cyc == dec_at + 1, "R9", "decision latency", cyc, dec_at + 1);
            chk(busy == 1'b0, "R7", "busy cleared with decision", busy, 0);
         end else begin
            if (!busy) busy_ok = 0;
            if (cyc == 0 && stray) begin
               home_rsp_valid = 1'b1; home_rsp_ptr_hit = 1'b1; home_rsp_ptr_host = ~nhost;
               place_rsp_valid = 1'b1; place_rsp_tile = ~ptile;
            end
            if (cyc == 0 && extra) begin
               req_valid = 1'b1; req_addr = addr ^ 32'h0004_0040;
            end
            if (near_look_valid) begin
               nn++; cn = dly;
               chk(near_look_addr == addr, "R1", "near probe address", near_look_addr, addr);
            end
            if (home_look_valid) begin
               nh++; ch = dly;
               chk(home_look_tile == home, "R2", "home tile", home_look_tile, home);
               chk(home_look_addr == addr, "R2", "home probe address", home_look_addr, addr);
            end
            if (place_req_valid) begin
               np++; cp = dly;
            end
            if (cn == 0) begin
               near_rsp_valid = 1'b1; near_rsp_hit = nhit; near_rsp_host = nhost; dec_at = cyc;
            end
            if (ch == 0) begin
               home_rsp_valid = 1'b1; home_rsp_ptr_hit = phit; home_rsp_ptr_host = phost;
               home_rsp_l2_hit = l2; dec_at = cyc;
            end
            if (cp == 0) begin
               place_rsp_valid = 1'b1; place_rsp_tile = ptile; dec_at = cyc;
            end
            if (cn >= 0) cn--;
            if (ch >= 0) ch--;
            if (cp >= 0) cp--;
         end
      end
      chk(seen, "R9", "decision issued", seen, 1);
      chk(nn == en, "R1", "near probes", nn, en);
      chk(nh == eh, "R2", "home probes", nh, eh);
      chk(np == ep, "R5", "placement requests", np, ep);
      chk(busy_ok, "R7", "busy held while resolving", busy_ok, 1);
      if (extra) begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!near_look_valid && !busy, "R7", "request while busy dropped", near_look_valid, 0);
         end
      end
   endtask

   task automatic stray_idle();
      @(negedge clk);
      near_rsp_valid = 1'b1; near_rsp_hit = 1'b1;
      home_rsp_valid = 1'b1; home_rsp_ptr_hit = 1'b1;
      place_rsp_valid = 1'b1;
      @(negedge clk);
      near_rsp_valid = 1'b0; home_rsp_valid = 1'b0; place_rsp_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!busy && !route_valid && !home_look_valid && !place_req_valid, "R8",
             "idle responses ignored", {busy, route_valid, home_look_valid, place_req_valid}, 0);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !route_valid && !near_look_valid && !near_put_valid && !auth_upd_valid,
          "R7", "reset state", {busy, route_valid, near_look_valid}, 0);
      // R1 near hit
      run("R1", {22'h12345, 4'd9, 6'd0}, 4'd3, 1, 4'd5, 0, 4'd0, 0, 4'd0, 0, 0, 0);
      // R3 principal hit
      run("R3", {22'h00abc, 4'd7, 6'd0}, 4'd3, 0, 4'd0, 1, 4'd9, 0, 4'd0, 1, 0, 0);
      // R4 home L2 hit
      run("R4", {22'h3f001, 4'd2, 6'd0}, 4'd6, 0, 4'd0, 0, 4'd0, 1, 4'd0, 0, 0, 0);
      // R3 principal hit wins over L2 hit
      run("R3", {22'h00777, 4'd4, 6'd0}, 4'd1, 0, 4'd0, 1, 4'd12, 1, 4'd0, 2, 0, 0);
      // R5 memory fetch placed away from home
      run("R5", {22'h1a2b3, 4'd7, 6'd0}, 4'd2, 0, 4'd0, 0, 4'd0, 0, 4'd11, 1, 0, 0);
      // R5 memory fetch placed at home: no pointers
      run("R5", {22'h0c0c0, 4'd7, 6'd0}, 4'd2, 0, 4'd0, 0, 4'd0, 0, 4'd7, 0, 0, 0);
      // R6 extreme address and requester, placed at tile 0
      run("R6", 32'hffff_ffff, 4'd15, 0, 4'd0, 0, 4'd0, 0, 4'd0, 2, 0, 0);
      // R6 requester 0, home 0, principal hit to tile 15
      run("R6", 32'h0000_0000, 4'd0, 0, 4'd0, 1, 4'd15, 0, 4'd0, 0, 0, 0);
      // R8 stray home and placement responses while waiting on the near table
      run("R8", {22'h2468a, 4'd10, 6'd0}, 4'd8, 0, 4'd0, 1, 4'd3, 0, 4'd0, 2, 1, 0);
      // R7 second request while busy
      run("R7", {22'h13579, 4'd5, 6'd0}, 4'd4, 0, 4'd0, 0, 4'd0, 1, 4'd0, 1, 0, 1);
      stray_idle();
      // R1 back to back with longer latency
      run("R1", {22'h0000f, 4'd1, 6'd0}, 4'd9, 1, 4'd14, 0, 4'd0, 0, 4'd0, 3, 0, 0);
      run("R5", {22'h0000f, 4'd1, 6'd0}, 4'd9, 0, 4'd0, 0, 4'd0, 0, 4'd14, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R9", "every request decided", expq.size(), 0);
      summary();
      $finish;
   end
endmodule